// File: doc/BRIEF.md
# JTAG Debug Port Scan Responder

This block is the target-side data path of a JTAG debug port. A TAP controller outside the block supplies one-cycle capture and update strobes, a shift enable and the serial input bit. The block returns the serial output. It keeps its own instruction register, which selects one of four data registers: the identification code, the abort register, or the debug-port or access-port access register. Any other instruction code selects a one-bit bypass register.

The two access registers share one 35-bit chain. Its low three bits carry a request: bit 0 is the read flag (1 = read) and bits 2:1 are the word address A[3:2]. The upper 32 bits carry data. On capture, the low three bits return an acknowledge code and the upper bits return the result of the previous read. Reads are therefore posted: a read issued on one scan is collected on a later scan.

Debug-port registers are decoded locally. Address 1 is the control/status word, address 2 is the port/bank selector, address 3 is the read buffer, and address 0 is reserved. Access-port requests go out on a simple request/busy port, carrying the port number and bank taken from the selector. A scan that starts while an access is still running is refused with a WAIT acknowledge.

Top module: `dbg_port_scan`

## Requirements
- R1: Out of reset the instruction register holds 4'hE, and a data scan then captures the 32-bit IDCODE_VAL parameter. Every instruction scan captures 4'b0001. The codes are 4'h8 abort, 4'hA debug-port access, 4'hB access-port access and 4'hE identification.
- R2: Any other instruction code selects a 1-bit bypass register. It captures 0, so the serial output is the serial input delayed by one shift.
- R3: An access scan is 35 bits, shifted least significant bit first: bit 0 is the read flag (1 = read), bits 2:1 are A[3:2], bits 34:3 are data. When no access is running, the capture is ack 3'b010 in bits 2:0. A read of debug-port address 0 returns zero.
- R4: The data captured by an access scan is the result of the most recent completed read, not the read being requested. Reading the read buffer (A=3) returns that value and leaves it unchanged.
- R5: A scan whose capture falls while an access-port access is still running captures ack 3'b001. Its request is dropped, and no request reaches the access port. If control/status bit 0 (overrun detect) is 1, sticky overrun (bit 1) is set.
- R6: A write to the selector (A=2) keeps bits 31:24 (port number) and bits 7:4 (bank). Reads of the selector return only those bits. Access-port requests carry ap_sel = port number and ap_addr = {bank, A[3:2]}.
- R7: An update of the abort register with data bit 0 = 1 pulses ap_abort once and ends the running access. The next access scan captures ack OK, and the running access's read result is not written to the read buffer.
- R8: Writing control/status clears sticky overrun (bit 1) and sticky error (bit 5) where the written bit is 1, leaves them unchanged where it is 0, and loads bit 0 from the data.
- R9: An access completing with ap_err high sets sticky error (bit 5). While bit 1 or bit 5 is set, access-port requests are acknowledged OK but are not forwarded, and they leave the read buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the TAP controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_capture | input | 1 | Instruction capture strobe |
| ir_shift | input | 1 | Instruction shift enable |
| ir_update | input | 1 | Instruction update strobe |
| dr_capture | input | 1 | Data capture strobe |
| dr_shift | input | 1 | Data shift enable |
| dr_update | input | 1 | Data update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| ap_req | output | 1 | One-cycle access-port request |
| ap_wr | output | 1 | Request is a write |
| ap_sel | output | 8 | Access-port number |
| ap_addr | output | 6 | Bank and word address |
| ap_wdata | output | 32 | Write data |
| ap_abort | output | 1 | One-cycle abort pulse |
| ap_busy | input | 1 | Access port is processing a request |
| ap_rdata | input | 32 | Read result, valid when busy falls |
| ap_err | input | 1 | Access failed, valid when busy falls |

## Verification
The assertions rely on four conditions at the block's edge:
- The TAP strobes are mutually exclusive, and each capture is followed by shifts and then an update.
- The access port raises ap_busy in the cycle after it sees ap_req.
- The access port holds ap_busy until ap_rdata and ap_err are valid.
- The access port drops ap_busy on an abort.

The bench drives the strobes only through whole-scan tasks, so a scan is never cut short. Its access-port stub follows the busy contract, with a latency the test can change. That latency is made long to provoke WAIT and abort, and short elsewhere so that accesses finish before the next capture.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int unsigned IR_W  = 4;
  localparam int unsigned REQ_W = 3;

  localparam logic [IR_W-1:0] IR_ABORT  = 4'h8;
  localparam logic [IR_W-1:0] IR_DPACC  = 4'hA;
  localparam logic [IR_W-1:0] IR_APACC  = 4'hB;
  localparam logic [IR_W-1:0] IR_IDCODE = 4'hE;

  localparam logic [REQ_W-1:0] ACK_OK   = 3'b010;
  localparam logic [REQ_W-1:0] ACK_WAIT = 3'b001;

  // control/status bit positions
  localparam int unsigned CS_ORUNDET = 0;
  localparam int unsigned CS_STKORUN = 1;
  localparam int unsigned CS_STKERR  = 5;

  // debug-port word addresses
  localparam logic [1:0] DPA_RSVD   = 2'd0;
  localparam logic [1:0] DPA_CTRL   = 2'd1;
  localparam logic [1:0] DPA_SELECT = 2'd2;
  localparam logic [1:0] DPA_RDBUF  = 2'd3;

  typedef enum logic [1:0] {
    DR_BYPASS,
    DR_IDCODE,
    DR_ACCESS,
    DR_ABORT
  } dr_sel_e;
endpackage

// File: rtl/dps_ir.sv
module dps_ir #(
  parameter int unsigned         IR_W       = 4,
  parameter logic [IR_W-1:0]     RESET_CODE = 4'hE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            shift,
  input  logic            update,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            sr_lsb
);
  logic [IR_W-1:0] sr_q, sr_d;
  logic            sr_en;

  always_comb begin
    sr_en = capture | shift;
    sr_d  = sr_q;
    if (capture)    sr_d = IR_W'(1);
    else if (shift) sr_d = {tdi, sr_q[IR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      ir_q <= RESET_CODE;
    end else begin
      if (sr_en)  sr_q <= sr_d;
      if (update) ir_q <= sr_q;
    end
  end

  assign sr_lsb = sr_q[0];

  // R1
  ir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> (ir_q == $past(sr_q)));
endmodule

// File: rtl/dps_dr_chain.sv
module dps_dr_chain
  import dps_pkg::*;
#(
  parameter int unsigned       DATA_W     = 32,
  parameter logic [DATA_W-1:0] IDCODE_VAL = 32'h0DB5_3A1D
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  dr_sel_e                       sel,
  input  logic                          capture,
  input  logic                          shift,
  input  logic                          tdi,
  input  logic [REQ_W-1:0]              cap_ack,
  input  logic [DATA_W-1:0]             cap_data,
  output logic [DATA_W+REQ_W-1:0]       chain_q
);
  localparam int unsigned CHAIN_W = DATA_W + REQ_W;
  localparam int unsigned IDX_W   = $clog2(CHAIN_W);

  logic [CHAIN_W-1:0] chain_d, cap_val;
  logic [IDX_W-1:0]   top_idx;
  logic               chain_en;

  always_comb begin
    case (sel)
      DR_IDCODE: begin
        top_idx = IDX_W'(DATA_W - 1);
        cap_val = CHAIN_W'(IDCODE_VAL);
      end
      DR_ACCESS: begin
        top_idx = IDX_W'(CHAIN_W - 1);
        cap_val = {cap_data, cap_ack};
      end
      DR_ABORT: begin
        top_idx = IDX_W'(CHAIN_W - 1);
        cap_val = '0;
      end
      default: begin
        top_idx = '0;
        cap_val = '0;
      end
    endcase
  end

  always_comb begin
    chain_en = capture | shift;
    chain_d  = chain_q;
    if (capture) begin
      chain_d = cap_val;
    end else if (shift) begin
      chain_d          = chain_q >> 1;
      chain_d[top_idx] = tdi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain_q <= '0;
    else if (chain_en) chain_q <= chain_d;
  end
endmodule

// File: rtl/dps_access.sv
module dps_access
  import dps_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned APSEL_W = 8,
  parameter int unsigned BANK_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    is_dp,
  input  logic                    is_ap,
  input  logic                    is_abort,
  input  logic                    dr_capture,
  input  logic                    dr_update,
  input  logic                    req_rnw,
  input  logic [1:0]              req_a,
  input  logic [DATA_W-1:0]       req_data,
  output logic [REQ_W-1:0]        cap_ack,
  output logic [DATA_W-1:0]       cap_data,
  output logic                    ap_req_o,
  output logic                    ap_wr_o,
  output logic [APSEL_W-1:0]      ap_sel_o,
  output logic [BANK_W+1:0]       ap_addr_o,
  output logic [DATA_W-1:0]       ap_wdata_o,
  output logic                    ap_abort_o,
  input  logic                    ap_busy_i,
  input  logic [DATA_W-1:0]       ap_rdata_i,
  input  logic                    ap_err_i
);
  localparam int unsigned ADDR_W    = BANK_W + 2;
  localparam int unsigned APSEL_LSB = DATA_W - APSEL_W;
  localparam int unsigned BANK_LSB  = 4;

  logic                busy_q, busy_d, wait_q, wait_d, rdpend_q, rdpend_d;
  logic [DATA_W-1:0]   rdbuf_q, rdbuf_d, wdata_q, wdata_d;
  logic                det_q, det_d, orun_q, orun_d, err_q, err_d;
  logic [APSEL_W-1:0]  selap_q, selap_d, apsel_q, apsel_d;
  logic [BANK_W-1:0]   bank_q, bank_d;
  logic                req_q, req_d, wr_q, wr_d, abort_q, abort_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;

  logic                acc_sel, accept, sticky, done, issue, do_abort;
  logic [DATA_W-1:0]   cs_val, sel_val;

  always_comb begin
    acc_sel  = is_dp | is_ap;
    accept   = dr_update & acc_sel & ~wait_q;
    sticky   = orun_q | err_q;
    done     = busy_q & ~req_q & ~ap_busy_i;
    issue    = accept & is_ap & ~sticky;
    do_abort = dr_update & is_abort & req_data[0];

    cs_val             = '0;
    cs_val[CS_ORUNDET] = det_q;
    cs_val[CS_STKORUN] = orun_q;
    cs_val[CS_STKERR]  = err_q;

    sel_val                            = '0;
    sel_val[APSEL_LSB +: APSEL_W]      = selap_q;
    sel_val[BANK_LSB +: BANK_W]        = bank_q;
  end

  always_comb begin
    busy_d   = busy_q;
    wait_d   = wait_q;
    rdpend_d = rdpend_q;
    rdbuf_d  = rdbuf_q;
    det_d    = det_q;
    orun_d   = orun_q;
    err_d    = err_q;
    selap_d  = selap_q;
    bank_d   = bank_q;
    apsel_d  = apsel_q;
    wr_d     = wr_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    req_d    = 1'b0;
    abort_d  = 1'b0;

    if (dr_capture && acc_sel) wait_d = busy_q;

    if (done) begin
      busy_d   = 1'b0;
      rdpend_d = 1'b0;
      if (rdpend_q) rdbuf_d = ap_rdata_i;
      if (ap_err_i) err_d   = 1'b1;
    end

    if (dr_update && acc_sel && wait_q && det_q) orun_d = 1'b1;

    if (accept && is_dp) begin
      case (req_a)
        DPA_CTRL: begin
          if (req_rnw) begin
            rdbuf_d = cs_val;
          end else begin
            det_d = req_data[CS_ORUNDET];
            if (req_data[CS_STKORUN]) orun_d = 1'b0;
            if (req_data[CS_STKERR])  err_d  = 1'b0;
          end
        end
        DPA_SELECT: begin
          if (req_rnw) begin
            rdbuf_d = sel_val;
          end else begin
            selap_d = req_data[APSEL_LSB +: APSEL_W];
            bank_d  = req_data[BANK_LSB +: BANK_W];
          end
        end
        DPA_RDBUF: ;
        default: if (req_rnw) rdbuf_d = '0;
      endcase
    end

    if (issue) begin
      busy_d   = 1'b1;
      req_d    = 1'b1;
      wr_d     = ~req_rnw;
      addr_d   = {bank_q, req_a};
      wdata_d  = req_data;
      apsel_d  = selap_q;
      rdpend_d = req_rnw;
    end

    if (do_abort) begin
      busy_d   = 1'b0;
      rdpend_d = 1'b0;
      abort_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      wait_q   <= 1'b0;
      rdpend_q <= 1'b0;
      rdbuf_q  <= '0;
      det_q    <= 1'b0;
      orun_q   <= 1'b0;
      err_q    <= 1'b0;
      selap_q  <= '0;
      bank_q   <= '0;
      apsel_q  <= '0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      req_q    <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      wait_q   <= wait_d;
      rdpend_q <= rdpend_d;
      rdbuf_q  <= rdbuf_d;
      det_q    <= det_d;
      orun_q   <= orun_d;
      err_q    <= err_d;
      selap_q  <= selap_d;
      bank_q   <= bank_d;
      req_q    <= req_d;
      abort_q  <= abort_d;
      if (issue) begin
        apsel_q <= apsel_d;
        wr_q    <= wr_d;
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
      end
    end
  end

  assign cap_ack    = busy_q ? ACK_WAIT : ACK_OK;
  assign cap_data   = rdbuf_q;
  assign ap_req_o   = req_q;
  assign ap_wr_o    = wr_q;
  assign ap_sel_o   = apsel_q;
  assign ap_addr_o  = addr_q;
  assign ap_wdata_o = wdata_q;
  assign ap_abort_o = abort_q;

  // R3
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_req_o |-> $past(!busy_q));

  // R5
  wait_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_update && acc_sel && wait_q) |=> !ap_req_o);

  // R7
  abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_update && is_abort && req_data[0]) |=> (ap_abort_o && !busy_q));

  // R9
  sticky_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_update && is_ap && !wait_q && (orun_q || err_q)) |=> !ap_req_o);
endmodule

// File: rtl/dbg_port_scan.sv
module dbg_port_scan
  import dps_pkg::*;
#(
  parameter int unsigned       DATA_W     = 32,
  parameter logic [DATA_W-1:0] IDCODE_VAL = 32'h0DB5_3A1D,
  parameter int unsigned       APSEL_W    = 8,
  parameter int unsigned       BANK_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ir_capture,
  input  logic                 ir_shift,
  input  logic                 ir_update,
  input  logic                 dr_capture,
  input  logic                 dr_shift,
  input  logic                 dr_update,
  input  logic                 tdi,
  output logic                 tdo,
  output logic                 ap_req,
  output logic                 ap_wr,
  output logic [APSEL_W-1:0]   ap_sel,
  output logic [BANK_W+1:0]    ap_addr,
  output logic [DATA_W-1:0]    ap_wdata,
  output logic                 ap_abort,
  input  logic                 ap_busy,
  input  logic [DATA_W-1:0]    ap_rdata,
  input  logic                 ap_err
);
  localparam int unsigned CHAIN_W = DATA_W + REQ_W;

  logic [IR_W-1:0]    ir_q;
  logic               ir_lsb;
  logic [CHAIN_W-1:0] chain;
  logic [REQ_W-1:0]   cap_ack;
  logic [DATA_W-1:0]  cap_data;
  dr_sel_e            dr_sel;
  logic               is_dp, is_ap, is_abort;

  dps_ir #(.IR_W(IR_W), .RESET_CODE(IR_IDCODE)) ir_i (
    .clk(clk), .rst_n(rst_n), .capture(ir_capture), .shift(ir_shift),
    .update(ir_update), .tdi(tdi), .ir_q(ir_q), .sr_lsb(ir_lsb)
  );

  always_comb begin
    is_dp    = (ir_q == IR_DPACC);
    is_ap    = (ir_q == IR_APACC);
    is_abort = (ir_q == IR_ABORT);
    case (ir_q)
      IR_DPACC, IR_APACC: dr_sel = DR_ACCESS;
      IR_ABORT:           dr_sel = DR_ABORT;
      IR_IDCODE:          dr_sel = DR_IDCODE;
      default:            dr_sel = DR_BYPASS;
    endcase
  end

  dps_dr_chain #(.DATA_W(DATA_W), .IDCODE_VAL(IDCODE_VAL)) chain_i (
    .clk(clk), .rst_n(rst_n), .sel(dr_sel), .capture(dr_capture),
    .shift(dr_shift), .tdi(tdi), .cap_ack(cap_ack), .cap_data(cap_data),
    .chain_q(chain)
  );

  dps_access #(.DATA_W(DATA_W), .APSEL_W(APSEL_W), .BANK_W(BANK_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .is_dp(is_dp), .is_ap(is_ap),
    .is_abort(is_abort), .dr_capture(dr_capture), .dr_update(dr_update),
    .req_rnw(chain[0]), .req_a(chain[2:1]), .req_data(chain[CHAIN_W-1:REQ_W]),
    .cap_ack(cap_ack), .cap_data(cap_data),
    .ap_req_o(ap_req), .ap_wr_o(ap_wr), .ap_sel_o(ap_sel), .ap_addr_o(ap_addr),
    .ap_wdata_o(ap_wdata), .ap_abort_o(ap_abort), .ap_busy_i(ap_busy),
    .ap_rdata_i(ap_rdata), .ap_err_i(ap_err)
  );

  assign tdo = ir_shift ? ir_lsb : chain[0];
endmodule

// File: tb/dbg_port_scan_tb_top.sv
module dbg_port_scan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IDC = 32'h0DB5_3A1D;

  logic clk = 1'b0;
  logic rst_n;
  logic ir_capture, ir_shift, ir_update, dr_capture, dr_shift, dr_update, tdi;
  logic tdo, ap_req, ap_wr, ap_abort, ap_busy, ap_err;
  logic [7:0]  ap_sel;
  logic [5:0]  ap_addr;
  logic [31:0] ap_wdata, ap_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_port_scan #(.IDCODE_VAL(IDC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ir_capture(ir_capture), .ir_shift(ir_shift),
    .ir_update(ir_update), .dr_capture(dr_capture), .dr_shift(dr_shift),
    .dr_update(dr_update), .tdi(tdi), .tdo(tdo), .ap_req(ap_req), .ap_wr(ap_wr),
    .ap_sel(ap_sel), .ap_addr(ap_addr), .ap_wdata(ap_wdata), .ap_abort(ap_abort),
    .ap_busy(ap_busy), .ap_rdata(ap_rdata), .ap_err(ap_err)
  );

  int n_chk = 0, n_fail = 0;
  int ap_count = 0, abort_count = 0;
  bit finished = 0;

  function automatic logic [31:0] ap_val(input logic [7:0] s, input logic [5:0] a);
    return {8'h5A, 8'h00, s, 2'b00, a};
  endfunction

  // access-port stub
  int lat = 3;
  int cnt;
  bit stub_err = 0;
  logic [7:0] st_sel;
  logic [5:0] st_addr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_busy <= 1'b0; cnt <= 0; ap_rdata <= '0; ap_err <= 1'b0;
      st_sel <= '0; st_addr <= '0;
    end else if (ap_abort) begin
      ap_busy <= 1'b0;
    end else if (ap_req) begin
      ap_busy <= 1'b1; cnt <= lat; st_sel <= ap_sel; st_addr <= ap_addr;
    end else if (ap_busy) begin
      if (cnt <= 1) begin
        ap_busy <= 1'b0; ap_rdata <= ap_val(st_sel, st_addr); ap_err <= stub_err;
      end else cnt <= cnt - 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [34:0] act, input logic [34:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard queues
  logic [34:0] exp_v[$], exp_m[$], act_v[$];
  string exp_t[$];
  logic ape_wr[$];
  logic [7:0] ape_sel[$];
  logic [5:0] ape_addr[$];
  logic [31:0] ape_wd[$];

  initial begin
    forever begin
      wait (act_v.size() != 0);
      begin
        logic [34:0] a, e, m;
        string t;
        a = act_v.pop_front(); e = exp_v.pop_front();
        m = exp_m.pop_front(); t = exp_t.pop_front();
        check(((a ^ e) & m) == 0, t, a & m, e & m);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && ap_req) begin
      ap_count++;
      if (ape_wr.size() == 0) begin
        check(0, "R9 unexpected request", {29'b0, ap_addr}, 35'b0);
      end else begin
        logic w; logic [7:0] s; logic [5:0] ad; logic [31:0] wd;
        w = ape_wr.pop_front(); s = ape_sel.pop_front();
        ad = ape_addr.pop_front(); wd = ape_wd.pop_front();
        check(ap_wr == w && ap_sel == s && ap_addr == ad && (!w || ap_wdata == wd),
              "R6 request fields", {ap_wr, ap_sel, ap_addr, ap_wdata[19:0]},
              {w, s, ad, wd[19:0]});
      end
    end
    if (rst_n && ap_abort) abort_count++;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ir_scan(input logic [3:0] code, input string tag);
    logic [34:0] cap = '0;
    @(negedge clk) ir_capture = 1'b1;
    @(negedge clk) ir_capture = 1'b0;
    for (int i = 0; i < 4; i++) begin
      ir_shift = 1'b1; tdi = code[i];
      #1 cap[i] = tdo;
      @(negedge clk);
    end
    ir_shift = 1'b0; ir_update = 1'b1;
    @(negedge clk) ir_update = 1'b0;
    exp_v.push_back(35'h1); exp_m.push_back(35'hF); exp_t.push_back(tag);
    act_v.push_back(cap);
  endtask

  task automatic dr_scan(input int n, input logic [34:0] din, input logic [34:0] e,
                         input logic [34:0] m, input string tag);
    logic [34:0] cap = '0;
    exp_v.push_back(e); exp_m.push_back(m); exp_t.push_back(tag);
    @(negedge clk) dr_capture = 1'b1;
    @(negedge clk) dr_capture = 1'b0;
    for (int i = 0; i < n; i++) begin
      dr_shift = 1'b1; tdi = din[i];
      #1 cap[i] = tdo;
      @(negedge clk);
    end
    dr_shift = 1'b0; dr_update = 1'b1;
    @(negedge clk) dr_update = 1'b0;
    act_v.push_back(cap);
  endtask

  // access scan: expect OK ack and given captured data
  task automatic acc(input logic rnw, input logic [1:0] a, input logic [31:0] d,
                     input logic [31:0] exp_d, input string tag);
    dr_scan(35, {d, a, rnw}, {exp_d, 3'b010}, {35{1'b1}}, tag);
    idle(4);
  endtask

  task automatic push_ap(input logic w, input logic [5:0] ad, input logic [31:0] wd);
    ape_wr.push_back(w); ape_sel.push_back(8'h2A); ape_addr.push_back(ad); ape_wd.push_back(wd);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    int c0;
    rst_n = 1'b0;
    {ir_capture, ir_shift, ir_update, dr_capture, dr_shift, dr_update, tdi} = '0;
    idle(5);
    check(ap_req == 0 && ap_abort == 0, "R1 reset outputs", {33'b0, ap_req, ap_abort}, 35'b0);
    rst_n = 1'b1;
    idle(3);

    // R1 reset instruction selects identification code
    dr_scan(32, 35'h0, {3'b0, IDC}, {3'b0, {32{1'b1}}}, "R1 idcode after reset");
    ir_scan(4'hA, "R1 ir capture");

    // debug-port register traffic
    acc(1'b0, 2'd1, 32'h1, 32'h0, "R3 ctrl write ack OK");
    acc(1'b1, 2'd1, 32'h0, 32'h0, "R4 posted read returns old value");
    acc(1'b1, 2'd3, 32'h0, 32'h1, "R4 rdbuf returns ctrl");
    acc(1'b1, 2'd3, 32'h0, 32'h1, "R4 rdbuf no side effect");
    acc(1'b0, 2'd2, 32'h2A00_005F, 32'h1, "R6 select write");
    acc(1'b1, 2'd2, 32'h0, 32'h1, "R6 select read posted");
    acc(1'b1, 2'd0, 32'h0, 32'h2A00_0050, "R6 select masked readback");
    acc(1'b1, 2'd3, 32'h0, 32'h0, "R3 reserved address reads zero");

    // access-port traffic
    ir_scan(4'hB, "R1 ir capture");
    push_ap(1'b1, 6'h16, 32'hDEAD_BEEF);
    acc(1'b0, 2'd2, 32'hDEAD_BEEF, 32'h0, "R6 ap write");
    idle(10);
    push_ap(1'b0, 6'h15, 32'h0);
    acc(1'b1, 2'd1, 32'h0, 32'h0, "R4 ap read posted");
    idle(10);
    push_ap(1'b0, 6'h17, 32'h0);
    acc(1'b1, 2'd3, 32'h0, ap_val(8'h2A, 6'h15), "R4 previous ap read result");
    idle(10);
    ir_scan(4'hA, "R1 ir capture");
    acc(1'b1, 2'd3, 32'h0, ap_val(8'h2A, 6'h17), "R4 rdbuf holds last ap read");

    // R5 overrun while busy
    lat = 80;
    ir_scan(4'hB, "R1 ir capture");
    c0 = ap_count;
    push_ap(1'b1, 6'h14, 32'h1111_1111);
    dr_scan(35, {32'h1111_1111, 2'd0, 1'b0}, {ap_val(8'h2A, 6'h17), 3'b010}, {35{1'b1}}, "R5 first write OK");
    idle(2);
    dr_scan(35, {32'h2222_2222, 2'd1, 1'b0}, {32'h0, 3'b001}, 35'h7, "R5 wait ack");
    idle(100);
    check(ap_count == c0 + 1, "R5 dropped request", 35'(ap_count - c0), 35'd1);
    lat = 3;
    ir_scan(4'hA, "R1 ir capture");
    acc(1'b1, 2'd1, 32'h0, ap_val(8'h2A, 6'h17), "R5 rdbuf untouched by wait");
    acc(1'b1, 2'd3, 32'h0, 32'h3, "R5 sticky overrun set");

    // R9 sticky overrun blocks access port
    ir_scan(4'hB, "R1 ir capture");
    c0 = ap_count;
    acc(1'b1, 2'd0, 32'h0, 32'h3, "R9 blocked read acked OK");
    idle(10);
    check(ap_count == c0, "R9 no forward under overrun", 35'(ap_count - c0), 35'd0);
    ir_scan(4'hA, "R1 ir capture");
    acc(1'b0, 2'd1, 32'h1, 32'h3, "R9 blocked read left rdbuf");
    acc(1'b1, 2'd1, 32'h0, 32'h3, "R8 ctrl read");
    acc(1'b1, 2'd3, 32'h0, 32'h3, "R8 zero write keeps overrun");
    acc(1'b0, 2'd1, 32'h3, 32'h3, "R8 clear write");
    acc(1'b1, 2'd1, 32'h0, 32'h3, "R8 ctrl read");
    acc(1'b1, 2'd3, 32'h0, 32'h1, "R8 overrun cleared");

    // R9 sticky error
    stub_err = 1;
    ir_scan(4'hB, "R1 ir capture");
    push_ap(1'b1, 6'h14, 32'h33);
    acc(1'b0, 2'd0, 32'h33, 32'h1, "R9 erroring write");
    idle(10);
    stub_err = 0;
    c0 = ap_count;
    acc(1'b0, 2'd1, 32'h44, 32'h1, "R9 blocked write acked OK");
    idle(10);
    check(ap_count == c0, "R9 no forward under error", 35'(ap_count - c0), 35'd0);
    ir_scan(4'hA, "R1 ir capture");
    acc(1'b1, 2'd1, 32'h0, 32'h1, "R9 ctrl read");
    acc(1'b1, 2'd3, 32'h0, 32'h21, "R9 sticky error set");
    acc(1'b0, 2'd1, 32'h21, 32'h21, "R8 error clear write");
    acc(1'b1, 2'd1, 32'h0, 32'h21, "R8 ctrl read");
    acc(1'b1, 2'd3, 32'h0, 32'h1, "R8 error cleared");

    // R7 abort
    lat = 150;
    ir_scan(4'hB, "R1 ir capture");
    push_ap(1'b0, 6'h14, 32'h0);
    dr_scan(35, {32'h0, 2'd0, 1'b1}, {32'h1, 3'b010}, {35{1'b1}}, "R7 long read issued");
    ir_scan(4'h8, "R1 ir capture");
    c0 = abort_count;
    dr_scan(35, {32'h1, 3'b000}, 35'h0, 35'h0, "R7 abort scan");
    idle(2);
    check(abort_count == c0 + 1, "R7 abort pulse", 35'(abort_count - c0), 35'd1);
    lat = 3;
    ir_scan(4'hA, "R1 ir capture");
    acc(1'b1, 2'd1, 32'h0, 32'h1, "R7 OK after abort, no read result");
    acc(1'b1, 2'd3, 32'h0, 32'h1, "R7 no overrun after abort");

    // R2 bypass and R1 identification again
    ir_scan(4'h3, "R1 ir capture");
    dr_scan(4, 35'b1011, 35'b0110, 35'hF, "R2 bypass delay");
    ir_scan(4'h9, "R1 ir capture");
    dr_scan(4, 35'b0101, 35'b1010, 35'hF, "R2 bypass other code");
    ir_scan(4'hE, "R1 ir capture");
    dr_scan(32, 35'h0, {3'b0, IDC}, {3'b0, {32{1'b1}}}, "R1 idcode select");

    idle(5);
    wait (act_v.size() == 0);
    check(ape_wr.size() == 0, "R6 all expected requests seen", 35'(ape_wr.size()), 35'd0);
    report();
  end
endmodule